// File: doc/BRIEF.md
# UART Status Register Bank

This block holds the two 16-bit status words of a UART and its test-status word. Each status word combines live level bits with stored sticky bits. The live bits come from FIFO occupancy and from the modem inputs. The sticky bits latch error events and modem-line changes until software clears them by writing ones. The test-status word reports whether each FIFO is empty or full, and it keeps a small software-writable field.

Reads are combinational and have no side effects. A write clears only the sticky bits that its register's fixed clear mask allows. A small control state machine decides when modem-line changes may be recorded. It has three states:
- `ST_PRIME`: the first cycle after reset or after soft reset is released. It captures a baseline of the modem inputs and records no change.
- `ST_LIVE`: normal operation, in which changes are recorded.
- `ST_HOLD`: soft reset is held low.

The transitions are:
- PRIME→LIVE when soft reset is high.
- PRIME→HOLD and LIVE→HOLD when soft reset goes low.
- HOLD→PRIME when soft reset is released.

Top module: `uart_stat_regs`

## Requirements
- R1: Status word 1 bit 13 reads 1 exactly when the TX free space (FIFO_DEPTH − tx_count) is greater than or equal to tx_thresh.
- R2: Status word 1 bit 9 reads 1 exactly when rx_count is greater than or equal to rx_thresh.
- R3: Status word 1 bit 14 follows cts_in. Bit 12 is set one clock after cts_in differs from its value on the previous clock, and it stays set after the line returns.
- R4: A write to status word 1 (reg_sel 0) clears exactly the bits set in both wr_data and 0x9D30. A parity-error pulse sets bit 15 and a framing-error pulse sets bit 10.
- R5: Status word 2 bit 0 reads 1 when rx_count is non-zero. Bits 14 and 3 read 1 when tx_count is zero.
- R6: Status word 2 bit 9 follows ri_in and bit 10 latches a change of it. Bit 5 follows dcd_in and bit 6 latches a change of it.
- R7: A write to status word 2 (reg_sel 1) clears exactly the bits set in both wr_data and 0xBDF6. An overrun pulse sets bit 1 and a break pulse sets bit 2.
- R8: After rst_n, and while soft_rst_n is low, the stored part of status word 1 is 0x2040 and the stored part of status word 2 is 0x4008. Event pulses are ignored while soft_rst_n is low.
- R9: The test word (reg_sel 2) shows RX empty at bit 5, TX empty at bit 6, RX full at bit 3 and TX full at bit 4. Only bits 13:9 are writable. reg_sel 3 reads zero.
- R10: When a sticky bit's set event and a clearing write fall in the same cycle, the bit ends set.
- R11: In the first cycle after rst_n or soft reset is released, no change bit is set, whatever level the modem inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_n | input | 1 | Synchronous active-low soft reset of the status words |
| tx_count | input | CNT_W | TX FIFO occupancy |
| rx_count | input | CNT_W | RX FIFO occupancy |
| tx_thresh | input | CNT_W | TX free-space threshold |
| rx_thresh | input | CNT_W | RX fill threshold |
| cts_in | input | 1 | Clear-to-send level |
| ri_in | input | 1 | Ring indicator level |
| dcd_in | input | 1 | Carrier-detect level |
| parity_err_evt | input | 1 | Parity error pulse |
| frame_err_evt | input | 1 | Framing error pulse |
| overrun_evt | input | 1 | RX overrun pulse |
| break_evt | input | 1 | Break detect pulse |
| reg_sel | input | 2 | Register select for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |

## Verification
The FIFO-level bits are tried with the TX count below, at and above the free-space threshold, and with both FIFOs empty and full. These patterns separate an off-by-one compare from a correct one.

The modem lines are toggled once and then returned, which shows that a change bit is sticky and not a live XOR. A line is also held high through reset, which separates a primed baseline from a zero baseline.

Writes of all ones show that each clear mask spares the unmasked bits. A set event coincident with a clearing write shows the priority. A pulse during soft reset shows that events are suppressed while the block is held.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_LIVE  = 2'd1,
        ST_HOLD  = 2'd2
    } stat_state_e;

    localparam int REG_W = 16;

    localparam logic [1:0] SEL_SR1 = 2'd0;
    localparam logic [1:0] SEL_SR2 = 2'd1;
    localparam logic [1:0] SEL_TST = 2'd2;

    // write-one-to-clear masks
    localparam logic [REG_W-1:0] SR1_CLR_MASK = 16'h9D30;
    localparam logic [REG_W-1:0] SR2_CLR_MASK = 16'hBDF6;

    // stored reset images
    localparam logic [REG_W-1:0] SR1_RST = 16'h2040;
    localparam logic [REG_W-1:0] SR2_RST = 16'h4008;

    // bits overlaid from live levels
    localparam logic [REG_W-1:0] SR1_LIVE = 16'h6200;
    localparam logic [REG_W-1:0] SR2_LIVE = 16'h4229;

    // bit positions of status word 1
    localparam int B1_PARITY = 15;
    localparam int B1_CTS    = 14;
    localparam int B1_TXRDY  = 13;
    localparam int B1_CTSCHG = 12;
    localparam int B1_FRAME  = 10;
    localparam int B1_RXRDY  = 9;

    // bit positions of status word 2
    localparam int B2_TXEMPTY = 14;
    localparam int B2_RICHG   = 10;
    localparam int B2_RI      = 9;
    localparam int B2_DCDCHG  = 6;
    localparam int B2_DCD     = 5;
    localparam int B2_TXDONE  = 3;
    localparam int B2_BREAK   = 2;
    localparam int B2_OVERRUN = 1;
    localparam int B2_RXDATA  = 0;

endpackage

// File: rtl/uart_stat_fsm.sv
module uart_stat_fsm
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_n,
    output logic arm
);

    stat_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = soft_rst_n ? ST_LIVE : ST_HOLD;
            ST_LIVE:  state_d = soft_rst_n ? ST_LIVE : ST_HOLD;
            ST_HOLD:  state_d = soft_rst_n ? ST_PRIME : ST_HOLD;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    always_comb begin
        arm = 1'b0;
        unique case (state_q)
            ST_LIVE:  arm = soft_rst_n;
            default:  arm = 1'b0;
        endcase
    end

    // R11: leaving hold always re-primes the baseline first
    a_r11_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && soft_rst_n) |=> (state_q == ST_PRIME && !arm));

    // R8: no change recording in the cycle after soft reset is seen
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n |=> !arm);

endmodule

// File: rtl/uart_stat_delta.sv
module uart_stat_delta #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] chg
);

    logic [N-1:0] copy_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) copy_q[i] <= 1'b0;
            else        copy_q[i] <= lvl[i];
        end
        assign chg[i] = arm & (lvl[i] ^ copy_q[i]);
    end

endmodule

// File: rtl/uart_stat_sticky.sv
module uart_stat_sticky #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   MASK = '0,
    parameter logic [W-1:0]   RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restore,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);

    logic [W-1:0] clr;

    assign clr = wr ? (wdata & MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= RST;
        else if (restore) q <= RST;
        else              q <= (q & ~clr) | set;
    end

    // R8: soft reset restores the image
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (q == RST));

    // R10: a set event survives a coincident clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && set != '0) |=> ((q & $past(set)) == $past(set)));

    // R4: masked ones clear when no event competes
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && wr && ((wdata & MASK & set) == '0))
        |=> ((q & $past(wdata & MASK)) == '0));

    // R4: bits outside the mask never clear
    a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !restore |=> ((q & ~MASK) == (($past(q) | $past(set)) & ~MASK)));

endmodule

// File: rtl/uart_stat_regs.sv
module uart_stat_regs
    import uart_stat_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_thresh,
    input  logic [CNT_W-1:0] rx_thresh,
    input  logic             cts_in,
    input  logic             ri_in,
    input  logic             dcd_in,
    input  logic             parity_err_evt,
    input  logic             frame_err_evt,
    input  logic             overrun_evt,
    input  logic             break_evt,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
    localparam int               N_LINES = 3;

    logic                arm;
    logic [N_LINES-1:0]  lines, chg;
    logic [REG_W-1:0]    sr1_set, sr2_set, sr1_q, sr2_q, sr1_live, sr2_live;
    logic [4:0]          tst_q;
    logic [CNT_W-1:0]    tx_free;
    logic                tx_empty, rx_empty, tx_full, rx_full;

    uart_stat_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_n (soft_rst_n),
        .arm        (arm)
    );

    assign lines = {dcd_in, ri_in, cts_in};

    uart_stat_delta #(.N(N_LINES)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .lvl   (lines),
        .chg   (chg)
    );

    always_comb begin
        sr1_set            = '0;
        sr1_set[B1_PARITY] = parity_err_evt;
        sr1_set[B1_FRAME]  = frame_err_evt;
        sr1_set[B1_CTSCHG] = chg[0];
        sr2_set             = '0;
        sr2_set[B2_RICHG]   = chg[1];
        sr2_set[B2_DCDCHG]  = chg[2];
        sr2_set[B2_OVERRUN] = overrun_evt;
        sr2_set[B2_BREAK]   = break_evt;
    end

    uart_stat_sticky #(.W(REG_W), .MASK(SR1_CLR_MASK), .RST(SR1_RST)) u_sr1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .restore (!soft_rst_n),
        .wr      (wr_en && reg_sel == SEL_SR1),
        .wdata   (wr_data),
        .set     (sr1_set),
        .q       (sr1_q)
    );

    uart_stat_sticky #(.W(REG_W), .MASK(SR2_CLR_MASK), .RST(SR2_RST)) u_sr2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .restore (!soft_rst_n),
        .wr      (wr_en && reg_sel == SEL_SR2),
        .wdata   (wr_data),
        .set     (sr2_set),
        .q       (sr2_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           tst_q <= '0;
        else if (wr_en && reg_sel == SEL_TST) tst_q <= wr_data[13:9];
    end

    assign tx_free  = DEPTH_C - tx_count;
    assign tx_empty = (tx_count == '0);
    assign rx_empty = (rx_count == '0);
    assign tx_full  = (tx_count == DEPTH_C);
    assign rx_full  = (rx_count == DEPTH_C);

    always_comb begin
        sr1_live             = '0;
        sr1_live[B1_CTS]     = cts_in;
        sr1_live[B1_TXRDY]   = (tx_free >= tx_thresh);
        sr1_live[B1_RXRDY]   = (rx_count >= rx_thresh);
        sr2_live             = '0;
        sr2_live[B2_TXEMPTY] = tx_empty;
        sr2_live[B2_TXDONE]  = tx_empty;
        sr2_live[B2_RI]      = ri_in;
        sr2_live[B2_DCD]     = dcd_in;
        sr2_live[B2_RXDATA]  = !rx_empty;
    end

    always_comb begin
        case (reg_sel)
            SEL_SR1: rd_data = (sr1_q & ~SR1_LIVE) | sr1_live;
            SEL_SR2: rd_data = (sr2_q & ~SR2_LIVE) | sr2_live;
            SEL_TST: rd_data = {2'b00, tst_q, 2'b00, tx_empty, rx_empty,
                                tx_full, rx_full, 3'b000};
            default: rd_data = '0;
        endcase
    end

    // R3: a CTS change one clock earlier, while armed, shows as a latched delta
    a_r3_cts_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && cts_in != $past(cts_in) && soft_rst_n) |=> sr1_q[B1_CTSCHG]);

endmodule

// File: tb/uart_stat_regs_tb.sv
module uart_stat_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, soft_rst_n = 1'b1;
    logic [CW-1:0] tx_count = '0, rx_count = '0, tx_thresh = CW'(16), rx_thresh = CW'(1);
    logic          cts_in = 0, ri_in = 0, dcd_in = 0;
    logic          parity_err_evt = 0, frame_err_evt = 0, overrun_evt = 0, break_evt = 0;
    logic [1:0]    reg_sel = '0;
    logic          wr_en = 0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   rd_data;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { logic [15:0] exp; string tag; } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_stat_regs #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .cts_in(cts_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .parity_err_evt(parity_err_evt), .frame_err_evt(frame_err_evt),
        .overrun_evt(overrun_evt), .break_evt(break_evt),
        .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    // driver side: select register, queue expected value
    task automatic expect_rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        reg_sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_sel = sel; wr_data = data; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    // monitor: compare a quarter period after the falling edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        expect_rd(2'd0, 16'h2040, "R8 sr1 reset");
        expect_rd(2'd1, 16'h4008, "R8 sr2 reset / R5 tx empty");
        expect_rd(2'd2, 16'h0060, "R9 test empty bits");
        expect_rd(2'd3, 16'h0000, "R9 unused select");

        @(negedge clk); tx_count = CW'(20);
        expect_rd(2'd0, 16'h0040, "R1 below threshold");
        @(negedge clk); tx_count = CW'(16);
        expect_rd(2'd0, 16'h2040, "R1 at threshold");
        expect_rd(2'd1, 16'h0000, "R5 tx not empty");
        @(negedge clk); rx_count = CW'(1);
        expect_rd(2'd0, 16'h2240, "R2 rx at threshold");
        expect_rd(2'd1, 16'h0001, "R5 rx data present");
        expect_rd(2'd2, 16'h0000, "R9 neither empty nor full");
        @(negedge clk); tx_count = CW'(32); rx_count = CW'(32);
        expect_rd(2'd2, 16'h0018, "R9 both full");
        @(negedge clk); tx_count = '0; rx_count = '0;

        @(negedge clk); cts_in = 1;
        expect_rd(2'd0, 16'h7040, "R3 cts live and delta");
        @(negedge clk); cts_in = 0;
        expect_rd(2'd0, 16'h3040, "R3 delta sticky");
        wr(2'd0, 16'h1000);
        expect_rd(2'd0, 16'h2040, "R4 clear delta");
        wr(2'd0, 16'hFFFF);
        expect_rd(2'd0, 16'h2040, "R4 unmasked bit6 kept");

        @(negedge clk); parity_err_evt = 1; frame_err_evt = 1;
        @(negedge clk); parity_err_evt = 0; frame_err_evt = 0;
        expect_rd(2'd0, 16'hA440, "R4 error events");
        wr(2'd0, 16'h8000);
        expect_rd(2'd0, 16'h2440, "R4 clear parity only");
        wr(2'd0, 16'h0400);
        expect_rd(2'd0, 16'h2040, "R4 clear framing");

        @(negedge clk); ri_in = 1;
        expect_rd(2'd1, 16'h4608, "R6 ri live and delta");
        @(negedge clk); dcd_in = 1;
        expect_rd(2'd1, 16'h4668, "R6 dcd live and delta");
        @(negedge clk); overrun_evt = 1; break_evt = 1;
        @(negedge clk); overrun_evt = 0; break_evt = 0;
        expect_rd(2'd1, 16'h466E, "R7 overrun and break");
        wr(2'd1, 16'hFFFF);
        expect_rd(2'd1, 16'h4228, "R7 clear all masked");

        // R10: change of ri together with a write clearing its delta
        @(negedge clk);
        ri_in = 0; reg_sel = 2'd1; wr_data = 16'h0400; wr_en = 1;
        @(negedge clk); wr_en = 0;
        expect_rd(2'd1, 16'h4428, "R10 delta set beats clear");
        @(negedge clk);
        overrun_evt = 1; reg_sel = 2'd1; wr_data = 16'h0002; wr_en = 1;
        @(negedge clk); wr_en = 0; overrun_evt = 0;
        expect_rd(2'd1, 16'h442A, "R10 event beats clear");

        // R8: soft reset with an event during hold
        @(negedge clk); soft_rst_n = 0; parity_err_evt = 1;
        @(negedge clk); soft_rst_n = 1; parity_err_evt = 0;
        repeat (2) @(negedge clk);
        expect_rd(2'd0, 16'h2040, "R8 sr1 after soft reset");
        expect_rd(2'd1, 16'h4028, "R8 sr2 after soft reset");

        wr(2'd2, 16'hFFFF);
        expect_rd(2'd2, 16'h3E60, "R9 writable field");
        wr(2'd2, 16'h0000);
        expect_rd(2'd2, 16'h0060, "R9 field cleared");

        // R11: modem line high across reset gives no delta
        @(negedge clk); cts_in = 1; rst_n = 0;
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        expect_rd(2'd0, 16'h6040, "R11 no delta after reset");
        expect_rd(2'd2, 16'h0060, "R8 test word after reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule